// File: doc/BRIEF.md
# Memory response reorder buffer

This block sits between the point where memory requests are issued and the memory system. It hands completed responses to a register writeback consumer. Each load, atomic or store that is accepted gets a wrapping sequence tag. A fence is accepted without a tag, because it never produces a response. The number of loads and atomics in flight is bounded by one limit, and the number of stores in flight by a separate limit. A request waits at the issue port while its class is at its limit.

A static mode input selects how responses are released. In ordered mode, every tagged request reserves a slot in a circular table indexed by its tag at the moment it issues. An arriving response marks its slot complete. Only the oldest reserved slot may be delivered, and only once it is complete. In unordered mode, responses are queued by class as they arrive. Loads and atomics go to one queue and stores to another. The load queue always wins when both queues hold entries. In both modes a response that cannot be accepted sets a sticky error flag.

Top module: `resp_reorder_buf`

## Requirements
- R1: After synchronous reset `dlv_valid` and `err` are 0, and `iss_ready` is 1 for every request kind.
- R2: Kinds 2'b00 (load) and 2'b01 (atomic) form one class. A request of this class is refused (`iss_ready`=0) while LD_LIMIT of them are accepted and not yet delivered.
- R3: Kind 2'b10 (store) is refused while ST_LIMIT stores are accepted and not yet delivered, independently of the load class.
- R4: Each accepted non-fence request receives `iss_tag` equal to the previous such tag plus one, modulo 2^TAG_W, starting at 0 after reset. Kind 2'b11 (fence) is always accepted and consumes no tag.
- R5: In ordered mode (`cfg_ordered`=1), issue stalls while 2^TAG_W tagged requests are outstanding, even when both class limits have room.
- R6: In ordered mode, delivery follows issue order. A completed entry is not presented until every older entry has been delivered. The `dlv_is_store` output gives the class of the request.
- R7: In ordered mode, a response whose tag has no reserved slot sets `err`, which stays 1 until reset, and the response changes nothing else.
- R8: In unordered mode (`cfg_ordered`=0), responses of one class are delivered in arrival order, and the load class is presented whenever it holds an entry. A response's class is taken from `rsp_is_store`.
- R9: In unordered mode, a response arriving when its class queue already holds its class limit of entries sets sticky `err` and is dropped.
- R10: While `dlv_ready` is 0, a presented response stays presented with unchanged tag and class. The one exception is unordered mode when a store is presented, since a newer load then takes priority.
- R11: Each delivery frees one place in the class limit of the delivered class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_ordered | input | 1 | 1 selects ordered delivery; change only under reset |
| iss_valid | input | 1 | Request offered |
| iss_kind | input | 2 | 00 load, 01 atomic, 10 store, 11 fence |
| iss_ready | output | 1 | Request accepted this cycle if offered |
| iss_tag | output | TAG_W | Tag given to the offered request |
| rsp_valid | input | 1 | Memory response arrives |
| rsp_tag | input | TAG_W | Tag of the response |
| rsp_is_store | input | 1 | Response belongs to a store |
| dlv_valid | output | 1 | A response is presented to the writeback consumer |
| dlv_ready | input | 1 | Consumer takes the presented response |
| dlv_tag | output | TAG_W | Tag of the presented response |
| dlv_is_store | output | 1 | Presented response belongs to a store |
| err | output | 1 | Sticky protocol error |

## Verification
The bench builds the block with TAG_W=3 and both class limits at 6. With these values the 8-slot ordered table fills before either class limit does, so the table stall can be observed apart from the counter stalls. The same values also allow 12 requests in flight in unordered mode, and they exercise queue pointers that wrap at a depth that is not a power of two. Ordered mode is swept with several full-table response permutations. Unordered mode is swept with interleaved response and delivery orders, and every expected tag is computed from a small queue model in the bench.

// File: rtl/resp_reorder_buf.sv
module resp_reorder_buf #(
  parameter int TAG_W    = 3,
  parameter int LD_LIMIT = 4,
  parameter int ST_LIMIT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_ordered,
  input  logic             iss_valid,
  input  logic [1:0]       iss_kind,
  output logic             iss_ready,
  output logic [TAG_W-1:0] iss_tag,
  input  logic             rsp_valid,
  input  logic [TAG_W-1:0] rsp_tag,
  input  logic             rsp_is_store,
  output logic             dlv_valid,
  input  logic             dlv_ready,
  output logic [TAG_W-1:0] dlv_tag,
  output logic             dlv_is_store,
  output logic             err
);
  localparam int DEPTH = 1 << TAG_W;
  localparam int PW    = TAG_W + 1;
  localparam int LCW   = $clog2(LD_LIMIT + 1);
  localparam int SCW   = $clog2(ST_LIMIT + 1);
  localparam int LAW   = (LD_LIMIT > 1) ? $clog2(LD_LIMIT) : 1;
  localparam int SAW   = (ST_LIMIT > 1) ? $clog2(ST_LIMIT) : 1;

  logic [PW-1:0]    head, tail;
  logic [DEPTH-1:0] e_vld, e_done, e_st;
  logic [LCW-1:0]   ld_cnt, lq_n;
  logic [SCW-1:0]   st_cnt, sq_n;
  logic [TAG_W-1:0] lq_mem [LD_LIMIT];
  logic [TAG_W-1:0] sq_mem [ST_LIMIT];
  logic [LAW-1:0]   lq_wp, lq_rp;
  logic [SAW-1:0]   sq_wp, sq_rp;

  wire [TAG_W-1:0] hidx = head[TAG_W-1:0];
  wire [TAG_W-1:0] tidx = tail[TAG_W-1:0];
  wire ring_full = (tail - head) == PW'(DEPTH);
  wire k_fence   = iss_kind == 2'b11;
  wire k_store   = iss_kind == 2'b10;
  wire ld_room   = ld_cnt < LCW'(LD_LIMIT);
  wire st_room   = st_cnt < SCW'(ST_LIMIT);
  wire lq_full   = lq_n == LCW'(LD_LIMIT);
  wire sq_full   = sq_n == SCW'(ST_LIMIT);

  assign iss_ready = k_fence | (!(cfg_ordered && ring_full) && (k_store ? st_room : ld_room));
  assign iss_tag   = tidx;

  wire iss_take = iss_valid & iss_ready & !k_fence;

  always_comb begin
    if (cfg_ordered) begin
      dlv_valid    = e_vld[hidx] & e_done[hidx];
      dlv_tag      = hidx;
      dlv_is_store = e_st[hidx];
    end else if (lq_n != '0) begin
      dlv_valid    = 1'b1;
      dlv_tag      = lq_mem[lq_rp];
      dlv_is_store = 1'b0;
    end else begin
      dlv_valid    = sq_n != '0;
      dlv_tag      = sq_mem[sq_rp];
      dlv_is_store = 1'b1;
    end
  end

  wire dlv_take = dlv_valid & dlv_ready;
  wire rsp_hit  = rsp_valid & e_vld[rsp_tag];
  wire lq_push  = !cfg_ordered & rsp_valid & !rsp_is_store & !lq_full;
  wire sq_push  = !cfg_ordered & rsp_valid & rsp_is_store & !sq_full;
  wire lq_pop   = !cfg_ordered & dlv_take & !dlv_is_store;
  wire sq_pop   = !cfg_ordered & dlv_take & dlv_is_store;
  wire bad_rsp  = rsp_valid & (cfg_ordered ? !e_vld[rsp_tag]
                                           : (rsp_is_store ? sq_full : lq_full));

  always_ff @(posedge clk) begin
    if (rst) begin
      head   <= '0;
      tail   <= '0;
      e_vld  <= '0;
      e_done <= '0;
      e_st   <= '0;
    end else begin
      if (iss_take) begin
        tail <= tail + PW'(1);
        if (cfg_ordered) begin
          e_vld[tidx]  <= 1'b1;
          e_done[tidx] <= 1'b0;
          e_st[tidx]   <= k_store;
        end
      end
      if (cfg_ordered && rsp_hit)
        e_done[rsp_tag] <= 1'b1;
      if (cfg_ordered && dlv_take) begin
        e_vld[hidx] <= 1'b0;
        head        <= head + PW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_cnt <= '0;
      st_cnt <= '0;
      err    <= 1'b0;
    end else begin
      ld_cnt <= ld_cnt + LCW'(iss_take & !k_store) - LCW'(dlv_take & !dlv_is_store);
      st_cnt <= st_cnt + SCW'(iss_take & k_store) - SCW'(dlv_take & dlv_is_store);
      if (bad_rsp)
        err <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lq_wp <= '0;
      lq_rp <= '0;
      lq_n  <= '0;
    end else begin
      if (lq_push)
        lq_wp <= (lq_wp == LAW'(LD_LIMIT - 1)) ? '0 : lq_wp + LAW'(1);
      if (lq_pop)
        lq_rp <= (lq_rp == LAW'(LD_LIMIT - 1)) ? '0 : lq_rp + LAW'(1);
      lq_n <= lq_n + LCW'(lq_push) - LCW'(lq_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sq_wp <= '0;
      sq_rp <= '0;
      sq_n  <= '0;
    end else begin
      if (sq_push)
        sq_wp <= (sq_wp == SAW'(ST_LIMIT - 1)) ? '0 : sq_wp + SAW'(1);
      if (sq_pop)
        sq_rp <= (sq_rp == SAW'(ST_LIMIT - 1)) ? '0 : sq_rp + SAW'(1);
      sq_n <= sq_n + SCW'(sq_push) - SCW'(sq_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (lq_push) lq_mem[lq_wp] <= rsp_tag;
    if (sq_push) sq_mem[sq_wp] <= rsp_tag;
  end
endmodule

// File: rtl/resp_reorder_buf_chk.sv
module resp_reorder_buf_chk #(
  parameter int TAG_W    = 3,
  parameter int LD_LIMIT = 4,
  parameter int ST_LIMIT = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_ordered,
  input logic             iss_valid,
  input logic [1:0]       iss_kind,
  input logic             iss_ready,
  input logic [TAG_W-1:0] iss_tag,
  input logic             dlv_valid,
  input logic             dlv_ready,
  input logic [TAG_W-1:0] dlv_tag,
  input logic             dlv_is_store,
  input logic             err
);
  int ld_out, st_out;
  wire fire = iss_valid && iss_ready && iss_kind != 2'b11;
  wire took = dlv_valid && dlv_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_out <= 0;
      st_out <= 0;
    end else begin
      ld_out <= ld_out + ((fire && !iss_kind[1]) ? 1 : 0) - ((took && !dlv_is_store) ? 1 : 0);
      st_out <= st_out + ((fire && iss_kind == 2'b10) ? 1 : 0) - ((took && dlv_is_store) ? 1 : 0);
    end
  end

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !dlv_valid && !err);

  p_ld_limit_r2: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !iss_kind[1] && ld_out >= LD_LIMIT) |-> !iss_ready);

  p_st_limit_r3: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_kind == 2'b10 && st_out >= ST_LIMIT) |-> !iss_ready);

  p_fence_ready_r4: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_kind == 2'b11) |-> iss_ready);

  p_tag_step_r4: assert property (@(posedge clk) disable iff (rst)
    fire |=> iss_tag == $past(iss_tag) + TAG_W'(1));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && !dlv_ready && (cfg_ordered || !dlv_is_store))
      |=> dlv_valid && $stable(dlv_tag) && $stable(dlv_is_store));
endmodule

bind resp_reorder_buf resp_reorder_buf_chk #(
  .TAG_W(TAG_W), .LD_LIMIT(LD_LIMIT), .ST_LIMIT(ST_LIMIT)
) u_chk (
  .clk(clk), .rst(rst), .cfg_ordered(cfg_ordered),
  .iss_valid(iss_valid), .iss_kind(iss_kind), .iss_ready(iss_ready), .iss_tag(iss_tag),
  .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_tag(dlv_tag),
  .dlv_is_store(dlv_is_store), .err(err)
);

// File: tb/test_resp_reorder_buf.sv
module test_resp_reorder_buf;
  localparam int TW = 3;
  localparam int LL = 6;
  localparam int SL = 6;

  logic clk = 1'b0, rst = 1'b1, cfg_ordered = 1'b1;
  logic iss_valid = 1'b0, rsp_valid = 1'b0, rsp_is_store = 1'b0, dlv_ready = 1'b0;
  logic [1:0] iss_kind = 2'b00;
  logic [TW-1:0] rsp_tag = '0;
  logic iss_ready, dlv_valid, dlv_is_store, err;
  logic [TW-1:0] iss_tag, dlv_tag;

  int checks = 0, failures = 0;
  int exp_tag;
  bit m_vld[8], m_done[8], m_st[8];
  int m_head;
  int lq[64], sq[64];
  int lq_h, lq_t, sq_h, sq_t;

  resp_reorder_buf #(.TAG_W(TW), .LD_LIMIT(LL), .ST_LIMIT(SL)) i_resp_reorder_buf (
    .clk(clk), .rst(rst), .cfg_ordered(cfg_ordered),
    .iss_valid(iss_valid), .iss_kind(iss_kind), .iss_ready(iss_ready), .iss_tag(iss_tag),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_is_store(rsp_is_store),
    .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_tag(dlv_tag),
    .dlv_is_store(dlv_is_store), .err(err)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit ord);
    rst = 1'b1;
    cfg_ordered = ord;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_tag = 0;
    m_head = 0;
    lq_h = 0; lq_t = 0; sq_h = 0; sq_t = 0;
    for (int i = 0; i < 8; i++) begin m_vld[i] = 0; m_done[i] = 0; m_st[i] = 0; end
  endtask

  task automatic issue(input logic [1:0] k, output int tg, output bit acc);
    iss_valid = 1'b1; iss_kind = k;
    #1;
    acc = iss_ready; tg = int'(iss_tag);
    @(negedge clk);
    iss_valid = 1'b0;
  endtask

  task automatic respond(input int tg, input bit st);
    rsp_valid = 1'b1; rsp_tag = TW'(tg); rsp_is_store = st;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic take(input int tg, input bit st, input string req);
    dlv_ready = 1'b1;
    #1;
    chk(dlv_valid && int'(dlv_tag) == tg && dlv_is_store == st, req,
        dlv_valid ? int'(dlv_tag) + 100 * int'(dlv_is_store) : -1, tg + 100 * int'(st));
    @(negedge clk);
    dlv_ready = 1'b0;
  endtask

  task automatic issue_expect(input logic [1:0] k, input string req);
    int tg; bit acc;
    issue(k, tg, acc);
    chk(acc && tg == exp_tag % 8, req, acc ? tg : -1, exp_tag % 8);
    if (cfg_ordered) begin
      m_vld[exp_tag % 8] = 1; m_done[exp_tag % 8] = 0; m_st[exp_tag % 8] = (k == 2'b10);
    end
    exp_tag++;
  endtask

  task automatic drain_ordered();
    for (int n = 0; n < 8; n++) begin
      if (m_vld[m_head] && m_done[m_head]) begin
        take(m_head, m_st[m_head], "R6 oldest-first delivery");
        m_vld[m_head] = 0;
        m_head = (m_head + 1) % 8;
      end else begin
        #1;
        chk(!dlv_valid, "R6 no delivery before oldest completes", int'(dlv_valid), 0);
        break;
      end
    end
  endtask

  task automatic take_model(input string req);
    if (lq_h != lq_t) begin
      take(lq[lq_h], 1'b0, req); lq_h++;
    end else begin
      take(sq[sq_h], 1'b1, req); sq_h++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int tg; bit acc;
    int tags[6]; bit sts[6];
    @(negedge clk);
    do_reset(1'b1);
    #1;
    chk(!dlv_valid && !err, "R1 reset outputs idle", int'(dlv_valid) + 2 * int'(err), 0);
    chk(iss_ready, "R1 ready after reset", int'(iss_ready), 1);

    // ordered fill: load limit, fence, table-full stall
    for (int i = 0; i < 7; i++) begin
      if (i < LL) issue_expect(2'b00, "R2 R4 load accepted with next tag");
      else begin
        issue(2'b01, tg, acc);
        chk(!acc, "R2 load class at limit refused", int'(acc), 0);
      end
    end
    issue(2'b11, tg, acc);
    chk(acc, "R4 fence accepted", int'(acc), 1);
    issue_expect(2'b10, "R4 fence consumes no tag");
    issue_expect(2'b10, "R4 store tag");
    issue(2'b10, tg, acc);
    chk(!acc, "R5 table full stalls store", int'(acc), 0);

    // reverse completion, oldest last, with hold
    for (int t = 7; t >= 1; t--) begin
      respond(t, m_st[t]); m_done[t] = 1;
      #1;
      chk(!dlv_valid, "R6 younger completion waits", int'(dlv_valid), 0);
    end
    respond(0, 1'b0); m_done[0] = 1;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(dlv_valid && dlv_tag == 0, "R10 held while not ready", int'(dlv_tag), 0);
      @(negedge clk);
    end
    drain_ordered();
    iss_kind = 2'b00; #1;
    chk(iss_ready, "R11 load class freed after delivery", int'(iss_ready), 1);
    iss_kind = 2'b10; #1;
    chk(iss_ready, "R11 store class freed after delivery", int'(iss_ready), 1);
    @(negedge clk);

    // ordered permutation sweep
    for (int p = 0; p < 3; p++) begin
      int base;
      base = exp_tag % 8;
      for (int i = 0; i < 8; i++)
        issue_expect((i % 3 == 2) ? 2'b10 : 2'(i % 3), "R4 sweep tag");
      for (int i = 0; i < 8; i++) begin
        int t;
        t = (base + (3 * i + 5 * p) % 8) % 8;
        respond(t, m_st[t]); m_done[t] = 1;
        drain_ordered();
      end
    end

    // unreserved response
    respond(3, 1'b0);
    #1;
    chk(err, "R7 unreserved response flags err", int'(err), 1);
    chk(!dlv_valid, "R7 unreserved response has no effect", int'(dlv_valid), 0);
    @(negedge clk); #1;
    chk(err, "R7 err sticky", int'(err), 1);

    // unordered: priority of loads
    do_reset(1'b0);
    #1;
    chk(!err && !dlv_valid, "R1 reset clears err", int'(err), 0);
    issue_expect(2'b00, "R4 tag restarts");
    issue_expect(2'b10, "R4 tag");
    respond(1, 1'b1); sq[sq_t++] = 1;
    #1;
    chk(dlv_valid && dlv_tag == 1 && dlv_is_store, "R8 store presented alone", int'(dlv_tag), 1);
    respond(0, 1'b0); lq[lq_t++] = 0;
    #1;
    chk(dlv_valid && dlv_tag == 0 && !dlv_is_store, "R8 load overtakes store", int'(dlv_tag), 0);
    take_model("R8 load first");
    take_model("R8 then store");

    // unordered sweep
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 6; i++) begin
        tags[i] = exp_tag % 8; sts[i] = (i >= 3);
        issue_expect(i < 3 ? 2'(i % 2) : 2'b10, "R4 unordered tag");
      end
      for (int i = 0; i < 6; i++) begin
        int j;
        j = (5 * i + p) % 6;
        respond(tags[j], sts[j]);
        if (sts[j]) sq[sq_t++] = tags[j]; else lq[lq_t++] = tags[j];
        if (i % 2 == 1) take_model("R8 interleaved delivery order");
      end
      while (lq_h != lq_t || sq_h != sq_t) take_model("R8 drain order");
      #1;
      chk(!dlv_valid, "R8 queues empty", int'(dlv_valid), 0);
      @(negedge clk);
    end

    // unordered limits and overflow
    do_reset(1'b0);
    for (int i = 0; i < 7; i++) begin
      if (i < LL) begin tags[i % 6] = exp_tag % 8; issue_expect(2'b00, "R2 load accepted"); end
      else begin
        issue(2'b00, tg, acc);
        chk(!acc, "R2 unordered load limit", int'(acc), 0);
      end
    end
    for (int i = 0; i < 7; i++) begin
      if (i < SL) begin sq[sq_t++] = exp_tag % 8; issue_expect(2'b10, "R3 store accepted"); end
      else begin
        issue(2'b10, tg, acc);
        chk(!acc, "R3 store limit", int'(acc), 0);
      end
    end
    for (int i = 0; i < SL; i++) respond(sq[i], 1'b1);
    for (int i = 0; i < LL; i++) begin respond(tags[i], 1'b0); lq[lq_t++] = tags[i]; end
    #1;
    chk(!err, "R9 no error while queues fit", int'(err), 0);
    @(negedge clk);
    respond(5, 1'b0);
    #1;
    chk(err, "R9 push into full queue flags err", int'(err), 1);
    @(negedge clk);
    while (lq_h != lq_t || sq_h != sq_t) take_model("R9 contents intact");
    #1;
    chk(!dlv_valid, "R9 overflow response dropped", int'(dlv_valid), 0);
    iss_kind = 2'b01; #1;
    chk(iss_ready, "R11 atomic ready after drain", int'(iss_ready), 1);
    iss_kind = 2'b10; #1;
    chk(iss_ready, "R11 store ready after drain", int'(iss_ready), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule